// File: doc/BRIEF.md
# Receive Sampling Tap Tuner

This block calibrates the receive sampling point of a high-speed SD/eMMC host. It sweeps the input delay line through its 32 tap settings and returns the tap at the middle of the passing region. A single-cycle start pulse arms the sweep. The block raises an enable that gives the delay line over to its own tap output. It then steps the tap upward from 0. At every tap it asks an external command engine for one tuning transfer and waits for a pass or fail verdict.

The block keeps three pieces of state during the sweep: the number of failing taps, the last tap where a pass followed a fail, and the previous verdict. When the sweep ends, it treats the tap range as a ring. The centre is taken as the window start plus half of the passing length, wrapped modulo the tap count. That tap is driven out and held, and the enable stays high after tuning.

Top module: `rx_tap_tuner`

## Requirements
- R1: After synchronous reset, `busy_o`, `done_o`, `req_o` and `dly_en_o` are 0 and `tap_o` is 0.
- R2: A `start_i` seen while idle makes `busy_o` and `dly_en_o` 1 with `tap_o` = 0 on the next cycle.
- R3: The sweep issues exactly 32 requests, and the k-th request (counting from 0) is made with `tap_o` = k.
- R4: `tap_o` takes its new value at least one cycle before the request for that tap, and it does not change while the request is outstanding.
- R5: `req_o` is high for one cycle only. No further request is made until `rsp_done_i` is seen. A `rsp_done_i` while idle has no effect at the outputs.
- R6: The window start is the tap at which a pass (`rsp_pass_i` = 1) follows a fail. The verdict before tap 0 counts as a pass, so a pass at tap 0 records nothing. The start defaults to 0, and the latest such transition in the sweep wins.
- R7: The result is (start + ((32 − failing taps) >> 1)) mod 32, and it appears on `tap_o` in the cycle when `done_o` is 1.
- R8: If every tap passes the result is 16. If every tap fails the result is 0. `done_o` is raised in both cases.
- R9: `done_o` is a one-cycle pulse, and `busy_o` is 0 from that cycle on. After it, `tap_o` and `dly_en_o` = 1 hold until the next start or reset.
- R10: A `start_i` while `busy_o` is 1 is ignored: the sweep continues at the same tap.
- R11: A synchronous reset during a sweep returns the block to idle. A following sweep starts from cleared counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to begin tuning |
| rsp_done_i | input | 1 | Command engine finished one tuning transfer |
| rsp_pass_i | input | 1 | Verdict qualified by `rsp_done_i`: 1 pass, 0 fail |
| busy_o | output | 1 | Tuning in progress |
| done_o | output | 1 | One-cycle pulse: result valid on `tap_o` |
| req_o | output | 1 | One-cycle request for a tuning transfer |
| dly_en_o | output | 1 | Gives the input delay over to `tap_o` |
| tap_o | output | 5 | Delay tap in use |

## Verification
A wrong failing count or window start shows up only at the end. In the `done_o` cycle, `tap_o` differs from the ring-centre value for that pass/fail pattern, some 100 or more cycles after the fault. For that reason the patterns are chosen so that each register term moves the result on its own:
- a failing window in the middle of the range,
- a window at tap 0,
- a window at the top of the range,
- a window that wraps around,
- two separate windows.

Faults in the step sequencing appear sooner, at the first request that carries the wrong tap or follows too closely after the previous one. A reset that fails to clear state shows up as a wrong result on the sweep that follows.

// File: rtl/tap_tune_pkg.sv
package tap_tune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_APPLY = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_SOLVE = 3'd4
  } tune_state_e;
endpackage

// File: rtl/tap_tally.sv
module tap_tally #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             rec_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [TAP_W:0]   fail_cnt_o,
  output logic [TAP_W-1:0] win_start_o
);
  localparam int NUM_TAPS = 1 << TAP_W;

  logic prev_pass_q;
  logic rise_w;

  assign rise_w = rec_i && pass_i && !prev_pass_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      fail_cnt_o  <= '0;
      win_start_o <= '0;
      prev_pass_q <= 1'b1;
    end else if (rec_i) begin
      if (!pass_i) fail_cnt_o <= fail_cnt_o + 1'b1;
      if (rise_w) win_start_o <= tap_i;
      prev_pass_q <= pass_i;
    end
  end

  // R6
  win_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_w && !clr_i) |=> (win_start_o == $past(tap_i)));

  // R6
  win_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_i && !pass_i && !clr_i) |=> $stable(win_start_o));

  // R3
  fail_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fail_cnt_o <= (TAP_W+1)'(NUM_TAPS));
endmodule

// File: rtl/tap_centre.sv
module tap_centre #(
  parameter int TAP_W = 5
) (
  input  logic [TAP_W-1:0] win_start_i,
  input  logic [TAP_W:0]   fail_cnt_i,
  output logic [TAP_W-1:0] centre_o
);
  localparam int NUM_TAPS = 1 << TAP_W;

  function automatic logic [TAP_W-1:0] ring_centre(
    input logic [TAP_W-1:0] start,
    input logic [TAP_W:0]   fails
  );
    logic [TAP_W:0] pass_len;
    logic [TAP_W:0] sum;
    pass_len = (TAP_W+1)'(NUM_TAPS) - fails;
    sum      = {1'b0, start} + (pass_len >> 1);
    return sum[TAP_W-1:0];
  endfunction

  assign centre_o = ring_centre(win_start_i, fail_cnt_i);
endmodule

// File: rtl/tap_sweep_fsm.sv
module tap_sweep_fsm
  import tap_tune_pkg::*;
#(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             rsp_done_i,
  input  logic [TAP_W-1:0] centre_i,
  output logic             clr_o,
  output logic             take_o,
  output logic             solve_o,
  output logic             req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             dly_en_o,
  output logic [TAP_W-1:0] tap_o
);
  localparam logic [TAP_W-1:0] LAST_TAP = '1;

  tune_state_e state_q;

  assign clr_o   = (state_q == ST_IDLE) && start_i;
  assign take_o  = (state_q == ST_WAIT) && rsp_done_i;
  assign solve_o = (state_q == ST_SOLVE);
  assign req_o   = (state_q == ST_ISSUE);
  assign busy_o  = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      tap_o    <= '0;
      dly_en_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          dly_en_o <= 1'b1;
          tap_o    <= '0;
          state_q  <= ST_APPLY;
        end
        ST_APPLY: state_q <= ST_ISSUE;
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (rsp_done_i) begin
          if (tap_o == LAST_TAP) begin
            state_q <= ST_SOLVE;
          end else begin
            tap_o   <= tap_o + 1'b1;
            state_q <= ST_APPLY;
          end
        end
        ST_SOLVE: begin
          tap_o   <= centre_i;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> (busy_o && dly_en_o && tap_o == '0));

  // R4
  tap_settled_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> $stable(tap_o));

  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o) && dly_en_o));

  // R10
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

// File: rtl/rx_tap_tuner.sv
module rx_tap_tuner #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             rsp_done_i,
  input  logic             rsp_pass_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             req_o,
  output logic             dly_en_o,
  output logic [TAP_W-1:0] tap_o
);
  logic             sweep_clr_w;
  logic             verdict_take_w;
  logic             solve_w;
  logic [TAP_W:0]   fail_cnt_w;
  logic [TAP_W-1:0] win_start_w;
  logic [TAP_W-1:0] centre_w;

  tap_sweep_fsm #(.TAP_W(TAP_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .rsp_done_i (rsp_done_i),
    .centre_i   (centre_w),
    .clr_o      (sweep_clr_w),
    .take_o     (verdict_take_w),
    .solve_o    (solve_w),
    .req_o      (req_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .dly_en_o   (dly_en_o),
    .tap_o      (tap_o)
  );

  tap_tally #(.TAP_W(TAP_W)) u_tally (
    .clk         (clk),
    .rst         (rst),
    .clr_i       (sweep_clr_w),
    .rec_i       (verdict_take_w),
    .pass_i      (rsp_pass_i),
    .tap_i       (tap_o),
    .fail_cnt_o  (fail_cnt_w),
    .win_start_o (win_start_w)
  );

  tap_centre #(.TAP_W(TAP_W)) u_centre (
    .win_start_i (win_start_w),
    .fail_cnt_i  (fail_cnt_w),
    .centre_o    (centre_w)
  );

  // R7
  result_load_chk: assert property (@(posedge clk) disable iff (rst)
    solve_w |=> (done_o && tap_o == $past(centre_w)));

  // R5
  take_only_waiting_chk: assert property (@(posedge clk) disable iff (rst)
    verdict_take_w |-> (busy_o && !req_o));
endmodule

// File: tb/rx_tap_tuner_bench.sv
module rx_tap_tuner_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       rsp_done_i = 1'b0;
  logic       rsp_pass_i = 1'b0;
  logic       busy_o, done_o, req_o, dly_en_o;
  logic [4:0] tap_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_tap_tuner u_rx_tap_tuner (
    .clk(clk), .rst(rst), .start_i(start_i), .rsp_done_i(rsp_done_i),
    .rsp_pass_i(rsp_pass_i), .busy_o(busy_o), .done_o(done_o), .req_o(req_o),
    .dly_en_o(dly_en_o), .tap_o(tap_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_tap(input logic [31:0] p);
    int fails = 32 - $countones(p);
    int start = 0;
    for (int i = 1; i < 32; i++)
      if (p[i] && !p[i-1]) start = i;
    return (start + (32 - fails) / 2) % 32;
  endfunction

  task automatic sweep(input logic [31:0] pat, input int lat, input int stop_at,
                       input int glitch_k, input string rtag);
    int n;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o && dly_en_o && tap_o == 0, "R2", {busy_o, dly_en_o, tap_o}, 'b11_00000);
    for (int k = 0; k < stop_at; k++) begin
      n = 0;
      while (!req_o && n < 100) begin @(negedge clk); n++; end
      chk(req_o && tap_o == 5'(k), "R3", tap_o, k);
      if (k == glitch_k) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(!req_o, "R5", req_o, 0);
      if (k == glitch_k) chk(busy_o && tap_o == 5'(k), "R10", tap_o, k);
      for (int w = 0; w < lat; w++) begin
        chk(!req_o && tap_o == 5'(k), "R4", tap_o, k);
        @(negedge clk);
      end
      rsp_done_i = 1'b1;
      rsp_pass_i = pat[k];
      @(negedge clk);
      rsp_done_i = 1'b0;
      rsp_pass_i = 1'b0;
    end
    if (stop_at == 32) begin
      n = 0;
      while (!done_o && n < 20) begin @(negedge clk); n++; end
      chk(done_o && tap_o == 5'(ref_tap(pat)), rtag, tap_o, ref_tap(pat));
      chk(!busy_o, "R9", busy_o, 0);
      @(negedge clk);
      chk(!done_o && dly_en_o && tap_o == 5'(ref_tap(pat)), "R9", tap_o, ref_tap(pat));
      repeat (3) @(negedge clk);
      chk(!req_o && !busy_o && tap_o == 5'(ref_tap(pat)), "R9", tap_o, ref_tap(pat));
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy_o && !done_o && !req_o && !dly_en_o && tap_o == 0, "R1",
        {busy_o, done_o, req_o, dly_en_o, tap_o}, 0);
  endtask

  task automatic t_idle_done();
    @(negedge clk) begin rsp_done_i = 1'b1; rsp_pass_i = 1'b1; end
    @(negedge clk) begin rsp_done_i = 1'b0; rsp_pass_i = 1'b0; end
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o && !req_o && tap_o == 0, "R5", {busy_o, done_o, req_o}, 0);
  endtask

  task automatic t_mid_reset();
    sweep(32'h0, 1, 7, -1, "R11");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy_o && !req_o && !dly_en_o && tap_o == 0, "R11",
        {busy_o, req_o, dly_en_o, tap_o}, 0);
    sweep(~32'h0000_3C00, 0, 32, -1, "R11");
  endtask

  initial begin
    t_reset();
    t_idle_done();
    sweep(~32'h0000_3C00, 0, 32, -1, "R7");   // fails 10..13 -> 28
    sweep(32'hFFFF_FFFF, 2, 32, 5, "R8");     // all pass -> 16, restart at tap 5
    sweep(32'h0000_0000, 1, 32, -1, "R8");    // all fail -> 0
    sweep(~32'h0000_000F, 0, 32, -1, "R6");   // fails 0..3 -> 18
    sweep(~32'hF000_0000, 3, 32, -1, "R6");   // fails 28..31, no rise -> 14
    sweep(~32'hC000_0003, 0, 32, -1, "R7");   // wrap fails -> 16
    sweep(~32'h0070_0018, 1, 32, -1, "R6");   // two windows -> 4
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule